// File: doc/BRIEF.md
# Audio Link Input Frame Assembler

This block sits on the codec side of an AC'97-style serial audio link and produces the frame that travels from codec to controller. It runs on the bit clock. Each time the frame sync input rises, it assembles one 256-bit frame and shifts it out MSB first on a single serial line. The frame has a 16-bit tag slot followed by twelve 20-bit data slots.

The tag slot carries a codec-ready flag and per-slot valid flags. Slots 1 and 2 return a control register read as an address echo and a data word. A read request is handed to the block by the output-direction decoder as a one-cycle strobe with its address and data. It is answered in the next frame only, never in the frame during which the strobe arrived. Slots 3 and 4 carry 18-bit left and right record samples, left-justified, with zero stuffing below them. Each sample is held from its valid strobe and latched into the frame at the frame boundary. Slots 5 to 12 are always zero.

Top module: `aclink_in_framer`

## Requirements
- R1: While `rst` is high on a clock edge, `sdata_in` becomes 0 after that edge, and any pending read answer or sample is discarded.
- R2: On the first edge where `sync` is high and was low at the previous edge, a frame loads. After that edge `sdata_in` shows frame bit 255, which is tag bit 15. That bit equals `codec_ready` as sampled at the load edge. Each later edge advances one bit toward bit 0. Once all 256 bits have been sent, the line stays 0 until the next frame.
- R3: Tag bits 14 and 13 (the slot 1 and slot 2 valid flags) are 1 only in the first frame loaded after a `rd_req` strobe, and 0 in every other frame.
- R4: Slot 1 holds `rd_addr` in slot bits 18:12, with bits 19 and 11:0 at 0. The whole slot is 0 when its valid flag is 0.
- R5: Slot 2 holds `rd_data` in slot bits 19:4, with bits 3:0 at 0. The whole slot is 0 when its valid flag is 0.
- R6: Slots 3 and 4 hold the left and right samples in slot bits 19:2, with bits 1:0 at 0. Tag bits 12 and 11 are 1 when a left or right valid strobe, respectively, arrived since the previous frame load. A slot with no new sample is all 0.
- R7: Tag bits 10:0 and slots 5 to 12 are always 0.
- R8: A read or sample strobe on the same edge as a frame load is not placed in that frame. It is placed in the following frame.
- R9: When several strobes of one kind arrive between two frame loads, the frame carries the value from the last of them.
- R10: Holding `sync` high for many cycles loads only one frame. Only a low-to-high change starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; a rising edge starts a frame |
| codec_ready | input | 1 | Ready flag placed in tag bit 15 |
| rd_req | input | 1 | One-cycle strobe: a register read was requested |
| rd_addr | input | 7 | Register index to echo in slot 1 |
| rd_data | input | 16 | Register contents to return in slot 2 |
| left_valid | input | 1 | Strobe: new left sample on `left_sample` |
| left_sample | input | 18 | Left record sample |
| right_valid | input | 1 | Strobe: new right sample on `right_sample` |
| right_sample | input | 18 | Right record sample |
| sdata_in | output | 1 | Serial frame output, MSB first |

## Verification
The frame load and a new read or sample strobe can land on the same bit-clock edge. That edge has to snapshot the old pending state and clear it, while also capturing the new strobe for the next frame. The bench provokes this by raising `sync` in the same cycle as `rd_req` and `left_valid`. The scoreboard then expects the load frame to carry neither item, and the frame after it to carry both with the strobed values. Repeated strobes within one frame, and a long-held `sync`, are compared bit by bit against frames the bench builds from the requirements.

// File: rtl/aclink_in_pkg.sv
package aclink_in_pkg;
  parameter int TAG_W   = 16;
  parameter int SLOT_W  = 20;
  parameter int NSLOT   = 12;
  parameter int ADDR_W  = 7;
  parameter int DATA_W  = 16;
  parameter int SMP_W   = 18;
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;

  // tag bit positions inside the tag slot
  localparam int TAG_READY = TAG_W - 1;
  localparam int TAG_ADDRV = TAG_W - 2;
  localparam int TAG_DATAV = TAG_W - 3;
  localparam int TAG_LEFTV = TAG_W - 4;
  localparam int TAG_RGHTV = TAG_W - 5;

  typedef struct packed {
    logic              ready;
    logic              addr_v;
    logic [ADDR_W-1:0] addr;
    logic              data_v;
    logic [DATA_W-1:0] data;
    logic              left_v;
    logic [SMP_W-1:0]  left;
    logic              right_v;
    logic [SMP_W-1:0]  right;
  } frame_fields_t;
endpackage

// File: rtl/aclink_pend_hold.sv
module aclink_pend_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  input  logic         load,
  output logic         pend,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      val  <= '0;
    end else if (strobe) begin
      pend <= 1'b1;
      val  <= din;
    end else if (load) begin
      pend <= 1'b0;
    end
  end

  // R8
  strobe_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (pend && val == $past(din)));

  // R3
  load_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !strobe) |=> !pend);
endmodule

// File: rtl/aclink_slot_pack.sv
module aclink_slot_pack
  import aclink_in_pkg::*;
(
  input  frame_fields_t        fld,
  output logic [FRAME_W-1:0]   frame
);
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] slot [NSLOT];

  always_comb begin
    tag            = '0;
    tag[TAG_READY] = fld.ready;
    tag[TAG_ADDRV] = fld.addr_v;
    tag[TAG_DATAV] = fld.data_v;
    tag[TAG_LEFTV] = fld.left_v;
    tag[TAG_RGHTV] = fld.right_v;
  end

  assign frame[FRAME_W-1 -: TAG_W] = tag;

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_slot
      if (k == 0) begin : g_addr
        // index sits in slot bits 18:12
        assign slot[k] = fld.addr_v
          ? {1'b0, fld.addr, {(SLOT_W-1-ADDR_W){1'b0}}} : '0;
      end else if (k == 1) begin : g_data
        assign slot[k] = fld.data_v
          ? {fld.data, {(SLOT_W-DATA_W){1'b0}}} : '0;
      end else if (k == 2) begin : g_left
        assign slot[k] = fld.left_v
          ? {fld.left, {(SLOT_W-SMP_W){1'b0}}} : '0;
      end else if (k == 3) begin : g_right
        assign slot[k] = fld.right_v
          ? {fld.right, {(SLOT_W-SMP_W){1'b0}}} : '0;
      end else begin : g_zero
        assign slot[k] = '0;
      end
      assign frame[FRAME_W-TAG_W-1-k*SLOT_W -: SLOT_W] = slot[k];
    end
  endgenerate
endmodule

// File: rtl/aclink_shifter.sv
module aclink_shifter #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] frame,
  output logic         sdata
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= frame;
    else           sh <= {sh[W-2:0], 1'b0};
  end

  assign sdata = sh[W-1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !sdata);

  // R2
  bit_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> sdata == $past(sh[W-2]));
endmodule

// File: rtl/aclink_in_framer.sv
module aclink_in_framer
  import aclink_in_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              codec_ready,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              left_valid,
  input  logic [SMP_W-1:0]  left_sample,
  input  logic              right_valid,
  input  logic [SMP_W-1:0]  right_sample,
  output logic              sdata_in
);
  logic sync_d;
  logic load;
  logic rq_pend, l_pend, r_pend;
  logic [ADDR_W+DATA_W-1:0] rq_val;
  logic [SMP_W-1:0] l_val, r_val;
  frame_fields_t fld;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk) begin
    if (rst) sync_d <= 1'b0;
    else     sync_d <= sync;
  end

  assign load = sync & ~sync_d;

  aclink_pend_hold #(.W(ADDR_W+DATA_W)) u_rq (
    .clk(clk), .rst(rst), .strobe(rd_req), .din({rd_addr, rd_data}),
    .load(load), .pend(rq_pend), .val(rq_val));

  aclink_pend_hold #(.W(SMP_W)) u_left (
    .clk(clk), .rst(rst), .strobe(left_valid), .din(left_sample),
    .load(load), .pend(l_pend), .val(l_val));

  aclink_pend_hold #(.W(SMP_W)) u_right (
    .clk(clk), .rst(rst), .strobe(right_valid), .din(right_sample),
    .load(load), .pend(r_pend), .val(r_val));

  always_comb begin
    fld.ready   = codec_ready;
    fld.addr_v  = rq_pend;
    fld.addr    = rq_val[ADDR_W+DATA_W-1 -: ADDR_W];
    fld.data_v  = rq_pend;
    fld.data    = rq_val[DATA_W-1:0];
    fld.left_v  = l_pend;
    fld.left    = l_val;
    fld.right_v = r_pend;
    fld.right   = r_val;
  end

  aclink_slot_pack u_pack (.fld(fld), .frame(frame));

  aclink_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .frame(frame), .sdata(sdata_in));

  // R2
  ready_tag_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sdata_in == $past(codec_ready));

  // R10
  held_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (sync && sync_d) |-> !load);
endmodule

// File: tb/aclink_in_framer_tb.sv
module aclink_in_framer_tb;
  localparam int FW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync = 1'b0, codec_ready = 1'b0;
  logic rd_req = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [15:0] rd_data = '0;
  logic left_valid = 1'b0, right_valid = 1'b0;
  logic [17:0] left_sample = '0, right_sample = '0;
  logic sdata_in;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [FW-1:0] expq [$];

  // bench-side pending model
  bit m_rq = 0, m_lv = 0, m_rv = 0;
  logic [6:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic [17:0] m_l = '0, m_r = '0;

  always #2.5 clk = ~clk;

  aclink_in_framer u_dut (
    .clk(clk), .rst(rst), .sync(sync), .codec_ready(codec_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .left_valid(left_valid), .left_sample(left_sample),
    .right_valid(right_valid), .right_sample(right_sample),
    .sdata_in(sdata_in));

  function automatic logic [FW-1:0] mk(bit rdy, bit rq, logic [6:0] a,
      logic [15:0] d, bit lv, logic [17:0] l, bit rv, logic [17:0] r);
    logic [FW-1:0] f = '0;
    f[255] = rdy; f[254] = rq; f[253] = rq; f[252] = lv; f[251] = rv;
    if (rq) begin f[238:232] = a; f[219:204] = d; end
    if (lv) f[199:182] = l;
    if (rv) f[179:162] = r;
    return f;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic frame_start(bit rdy, bit crq, logic [6:0] ca,
      logic [15:0] cd, bit cl, logic [17:0] clv);
    @(negedge clk);
    sync = 1'b1; codec_ready = rdy;
    expq.push_back(mk(rdy, m_rq, m_addr, m_data, m_lv, m_l, m_rv, m_r));
    m_rq = 0; m_lv = 0; m_rv = 0;
    if (crq) begin
      rd_req = 1'b1; rd_addr = ca; rd_data = cd;
      m_rq = 1; m_addr = ca; m_data = cd;
    end
    if (cl) begin
      left_valid = 1'b1; left_sample = clv; m_lv = 1; m_l = clv;
    end
    @(negedge clk);
    rd_req = 1'b0; left_valid = 1'b0;
    repeat (15) @(negedge clk);   // sync held high (R10)
    sync = 1'b0;
  endtask

  task automatic req(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; rd_data = d;
    m_rq = 1; m_addr = a; m_data = d;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic lsamp(logic [17:0] v);
    @(negedge clk);
    left_valid = 1'b1; left_sample = v; m_lv = 1; m_l = v;
    @(negedge clk); left_valid = 1'b0;
  endtask

  task automatic rsamp(logic [17:0] v);
    @(negedge clk);
    right_valid = 1'b1; right_sample = v; m_rv = 1; m_r = v;
    @(negedge clk); right_valid = 1'b0;
  endtask

  // monitor: pops an expected frame at every sync rise and compares it
  initial begin
    bit ps = 1'b0;
    int fidx = 0;
    forever begin
      @(posedge clk);
      if (sync && !ps && !rst) begin
        logic [FW-1:0] got, exp;
        exp = (expq.size() > 0) ? expq.pop_front() : '0;
        for (int i = 0; i < FW; i++) begin
          @(negedge clk);
          got[FW-1-i] = sdata_in;
        end
        // tag slot: R3 (read flags), R6 (sample flags), R7 (low bits)
        chk(got[255:240] == exp[255:240],
            $sformatf("R3/R6/R7 tag frame%0d", fidx),
            32'(got[255:240]), 32'(exp[255:240]));
        for (int k = 0; k < 12; k++) begin
          string rn;
          rn = (k == 0) ? "R4" : (k == 1) ? "R5" : (k < 4) ? "R6" : "R7";
          chk(got[239-20*k -: 20] == exp[239-20*k -: 20],
              $sformatf("%s slot%0d frame%0d", rn, k+1, fidx),
              32'(got[239-20*k -: 20]), 32'(exp[239-20*k -: 20]));
        end
        @(negedge clk);
        chk(sdata_in == 1'b0, "R2 idle after frame", 32'(sdata_in), 0);
        fidx++;
        ps = 1'b0;
      end else begin
        ps = sync;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sdata_in == 1'b0, "R1 reset output", 32'(sdata_in), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdata_in == 1'b0, "R1 idle after reset", 32'(sdata_in), 0);

    // F0: not ready, nothing pending
    frame_start(1'b0, 0, '0, '0, 0, '0);
    req(7'h1A, 16'h0D50);                 // R3 R4 R5
    lsamp(18'h2ABCD);                     // R6
    rsamp(18'h15432);
    repeat (260) @(negedge clk);

    // F1: all four flags; then two left strobes, last one wins (R9)
    frame_start(1'b1, 0, '0, '0, 0, '0);
    lsamp(18'h00001);
    lsamp(18'h3FFFF);
    repeat (260) @(negedge clk);

    // F2: read flags cleared (R3), only left sample
    frame_start(1'b1, 0, '0, '0, 0, '0);
    repeat (260) @(negedge clk);

    // F3: collision on load edge (R8)
    frame_start(1'b1, 1, 7'h7F, 16'hFFFF, 1, 18'h20001);
    repeat (260) @(negedge clk);

    // F4: collided items appear here
    frame_start(1'b0, 0, '0, '0, 0, '0);
    repeat (260) @(negedge clk);

    // reset discards pending items (R1)
    req(7'h02, 16'h8000);
    rsamp(18'h0F0F0);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    m_rq = 0; m_lv = 0; m_rv = 0;
    frame_start(1'b1, 0, '0, '0, 0, '0);
    repeat (270) @(negedge clk);

    chk(expq.size() == 0, "R2 all frames seen", 32'(expq.size()), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule